// File: doc/BRIEF.md
# Element Batch Hazard-Grouping Sequencer

This block splits a vector operation of VL elements into issue batches. Software supplies a horizontal-parallelism hint. Elements that share one hint group, meaning the same span between consecutive multiples of the hint, carry no register or memory hazards against each other. Elements in different groups must still be treated as dependent. After a start strobe, the sequencer walks element indices upward from zero. Each batch it offers is described by a first index, an element count, and an independence flag that tells downstream hazard logic whether it may skip inter-element checks inside that batch.

Each batch ends at the nearest of three points:
- the current index plus the effective batch size;
- the next multiple of the hint;
- VL.

The effective batch size is the hint reduced to the implementation's own maximum. The hint need not be a power of two. The next group boundary is kept by an accumulating counter, so no divider is needed.

A hint of zero means that no elements are independent, and each batch is then one element. The hint is also treated as zero whenever the operation belongs to an unsafe memory class: atomic, cache-inhibited, or reservation-based.

Batches leave on a valid/ready stream. While valid is high and ready is low, the descriptor does not change. A batch counts as consumed only on a cycle where both valid and ready are high. A one-cycle done pulse follows consumption of the last batch.

Top module: `hzgrp_sequencer`

## Requirements
- R1: After reset, `bat_valid_o` and `done_o` are low.
- R2: A start accepted while idle produces batches that begin at index 0 and are contiguous: each batch starts where the previous one ended. Together they cover exactly the effective VL elements and no more. The first batch is valid on the cycle after the start strobe.
- R3: No batch crosses a nonzero multiple of the effective hint. This holds whether or not the hint is a power of two.
- R4: No batch count exceeds the effective batch size. That size is the smaller of the effective hint and `impl_max_i`. An `impl_max_i` of zero counts as one.
- R5: With an effective hint of zero, every batch has a count of 1 and `bat_indep_o` low.
- R6: `unsafe_i` has three bits: bit 0 marks atomic, bit 1 cache-inhibited, bit 2 reservation. If any of these bits is set at start, the hint is treated as zero.
- R7: A hint greater than `maxvl_i` is reduced to `maxvl_i`. All elements up to VL then form one group, and batches are bounded only by the batch-size limit and VL.
- R8: `bat_indep_o` is high exactly when `bat_count_o` is greater than 1.
- R9: While `bat_valid_o` is high and `bat_ready_i` is low, the start, count and flag outputs hold their values.
- R10: `done_o` is high for exactly one cycle, on the cycle after the last batch is accepted. With an effective VL of zero, no batch is produced and `done_o` is high on the cycle after start.
- R11: A start strobe while batches are pending is ignored. The running sequence continues unchanged.
- R12: A VL greater than `maxvl_i` is reduced to `maxvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new sequence (honoured only while idle) |
| vl_i | input | IDX_W | Vector length |
| maxvl_i | input | IDX_W | Maximum vector length |
| hint_i | input | IDX_W | Horizontal-parallelism hint (0 = none) |
| impl_max_i | input | IDX_W | Implementation batch-size ceiling |
| unsafe_i | input | 3 | Unsafe memory class flags: atomic, cache-inhibited, reservation |
| bat_valid_o | output | 1 | Batch descriptor valid |
| bat_ready_i | input | 1 | Consumer accepts the batch |
| bat_start_o | output | IDX_W | First element index of the batch |
| bat_count_o | output | IDX_W | Element count of the batch |
| bat_indep_o | output | 1 | Batch elements are mutually hazard-free |
| done_o | output | 1 | One-cycle pulse when the sequence is complete |

## Verification
The bench aims at the cases where a boundary rule can be mishandled:
- **Non-power-of-two hints with a smaller implementation ceiling.** These produce short tail batches at group edges. A design that rounds the hint or lets a batch run past a multiple of the hint would emit an oversized count.
- **A hint of zero, any unsafe flag, and an `impl_max_i` of zero.** A design that honours the hint in these cases would mark multi-element batches independent. A design that passes a zero size through would stall or emit empty batches.
- **A hint above MAXVL, VL above MAXVL, and VL of zero.** Wrong clamping shows up as a wrong batch count, extra batches, or a missing done pulse.
- **Random back-pressure and a start strobe mid-run.** A descriptor that moves while stalled, or a sequence that restarts mid-run, breaks the expected index series.

// File: rtl/hzgrp_pkg.sv
package hzgrp_pkg;
  // Number of unsafe memory operation classes that disable the hint.
  localparam int unsigned N_UNSAFE = 3;
  localparam int unsigned CLS_ATOMIC = 0;
  localparam int unsigned CLS_NOCACHE = 1;
  localparam int unsigned CLS_RESV = 2;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/hzgrp_cfg.sv
module hzgrp_cfg
  import hzgrp_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input logic [IDX_W-1:0] vl_i,
  input logic [IDX_W-1:0] maxvl_i,
  input logic [IDX_W-1:0] hint_i,
  input logic [IDX_W-1:0] impl_max_i,
  input logic [N_UNSAFE-1:0] unsafe_i,
  output logic [IDX_W-1:0] eff_vl_o,
  output logic [IDX_W-1:0] eff_hint_o,
  output logic [IDX_W-1:0] eff_size_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic any_unsafe;
  logic [IDX_W-1:0] hint_cl;
  logic [IDX_W-1:0] impl_cl;

  // Any unsafe class forces the no-independence interpretation.
  always_comb begin
    any_unsafe = 1'b0;
    for (int i = 0; i < int'(N_UNSAFE); i++) begin
      any_unsafe = any_unsafe | unsafe_i[i];
    end
  end

  always_comb begin
    eff_vl_o = (vl_i > maxvl_i) ? maxvl_i : vl_i;
    hint_cl = (hint_i > maxvl_i) ? maxvl_i : hint_i;
    eff_hint_o = any_unsafe ? '0 : hint_cl;
    impl_cl = (impl_max_i == '0) ? ONE : impl_max_i;
    if (eff_hint_o == '0) begin
      eff_size_o = ONE;
    end else if (impl_cl < eff_hint_o) begin
      eff_size_o = impl_cl;
    end else begin
      eff_size_o = eff_hint_o;
    end
  end
endmodule

// File: rtl/hzgrp_bound.sv
module hzgrp_bound #(
  parameter int unsigned IDX_W = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic advance_i,
  input logic [IDX_W-1:0] load_hint_i,
  input logic [IDX_W-1:0] run_hint_i,
  output logic [IDX_W:0] bound_o
);
  // Next multiple of the hint above the current index; one extra bit
  // since the last boundary may sit beyond VL.
  logic [IDX_W:0] bound_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bound_q <= '0;
    end else if (load_i) begin
      bound_q <= {1'b0, load_hint_i};
    end else if (advance_i) begin
      bound_q <= bound_q + {1'b0, run_hint_i};
    end
  end

  assign bound_o = bound_q;
endmodule

// File: rtl/hzgrp_cut.sv
module hzgrp_cut #(
  parameter int unsigned IDX_W = 7
) (
  input logic [IDX_W-1:0] cur_i,
  input logic [IDX_W-1:0] size_i,
  input logic [IDX_W-1:0] vl_i,
  input logic [IDX_W-1:0] hint_i,
  input logic [IDX_W:0] bound_i,
  output logic [IDX_W-1:0] end_o,
  output logic [IDX_W-1:0] count_o,
  output logic last_o,
  output logic hit_bound_o
);
  logic [IDX_W:0] reach;
  logic [IDX_W:0] lim;
  logic grouped;

  always_comb begin
    grouped = (hint_i != '0);
    reach = {1'b0, cur_i} + {1'b0, size_i};
    lim = reach;
    if (grouped && (bound_i < lim)) lim = bound_i;
    if ({1'b0, vl_i} < lim) lim = {1'b0, vl_i};
    end_o = lim[IDX_W-1:0];
    count_o = end_o - cur_i;
    last_o = (end_o == vl_i);
    hit_bound_o = grouped && (lim == bound_i);
  end
endmodule

// File: rtl/hzgrp_sequencer.sv
module hzgrp_sequencer
  import hzgrp_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic [IDX_W-1:0] vl_i,
  input logic [IDX_W-1:0] maxvl_i,
  input logic [IDX_W-1:0] hint_i,
  input logic [IDX_W-1:0] impl_max_i,
  input logic [2:0] unsafe_i,
  output logic bat_valid_o,
  input logic bat_ready_i,
  output logic [IDX_W-1:0] bat_start_o,
  output logic [IDX_W-1:0] bat_count_o,
  output logic bat_indep_o,
  output logic done_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  seq_state_e state_q;
  logic [IDX_W-1:0] cur_q, vl_q, hint_q, size_q;
  logic done_q;

  logic [IDX_W-1:0] eff_vl, eff_hint, eff_size;
  logic [IDX_W-1:0] cut_end, cut_count;
  logic cut_last, cut_hit;
  logic [IDX_W:0] bound;
  logic take_start, accept;

  hzgrp_cfg #(.IDX_W(IDX_W)) u_cfg (
    .vl_i(vl_i),
    .maxvl_i(maxvl_i),
    .hint_i(hint_i),
    .impl_max_i(impl_max_i),
    .unsafe_i(unsafe_i),
    .eff_vl_o(eff_vl),
    .eff_hint_o(eff_hint),
    .eff_size_o(eff_size)
  );

  assign take_start = start_i && (state_q == SEQ_IDLE);
  assign accept = (state_q == SEQ_RUN) && bat_ready_i;

  hzgrp_bound #(.IDX_W(IDX_W)) u_bound (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .load_i(take_start),
    .advance_i(accept && cut_hit),
    .load_hint_i(eff_hint),
    .run_hint_i(hint_q),
    .bound_o(bound)
  );

  hzgrp_cut #(.IDX_W(IDX_W)) u_cut (
    .cur_i(cur_q),
    .size_i(size_q),
    .vl_i(vl_q),
    .hint_i(hint_q),
    .bound_i(bound),
    .end_o(cut_end),
    .count_o(cut_count),
    .last_o(cut_last),
    .hit_bound_o(cut_hit)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q <= '0;
      vl_q <= '0;
      hint_q <= '0;
      size_q <= ONE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_start) begin
        cur_q <= '0;
        vl_q <= eff_vl;
        hint_q <= eff_hint;
        size_q <= eff_size;
        if (eff_vl == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= SEQ_RUN;
        end
      end else if (accept) begin
        cur_q <= cut_end;
        if (cut_last) begin
          state_q <= SEQ_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign bat_valid_o = (state_q == SEQ_RUN);
  assign bat_start_o = cur_q;
  assign bat_count_o = cut_count;
  assign bat_indep_o = (cut_count > ONE);
  assign done_o = done_q;
endmodule

// File: rtl/hzgrp_chk.sv
module hzgrp_chk #(
  parameter int unsigned IDX_W = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bat_valid_o,
  input logic bat_ready_i,
  input logic [IDX_W-1:0] bat_start_o,
  input logic [IDX_W-1:0] bat_count_o,
  input logic bat_indep_o,
  input logic done_o
);
  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_valid_o && !bat_ready_i |=> bat_valid_o && $stable(bat_start_o)
      && $stable(bat_count_o) && $stable(bat_indep_o));

  // R2
  contiguous_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_valid_o && bat_ready_i |=> !bat_valid_o
      || (bat_start_o == IDX_W'($past(bat_start_o) + $past(bat_count_o))));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bat_valid_o);

  // R4
  count_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_valid_o |-> bat_count_o != '0);
endmodule

bind hzgrp_sequencer hzgrp_chk #(.IDX_W(IDX_W)) u_hzgrp_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .bat_valid_o(bat_valid_o),
  .bat_ready_i(bat_ready_i),
  .bat_start_o(bat_start_o),
  .bat_count_o(bat_count_o),
  .bat_indep_o(bat_indep_o),
  .done_o(done_o)
);

// File: tb/test_hzgrp_sequencer.sv
module test_hzgrp_sequencer;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] vl = '0, maxvl = '0, hint = '0, impl = '0;
  logic [2:0] uns = '0;
  logic ready = 1'b0;
  logic valid, indep, done;
  logic [W-1:0] bstart, bcount;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hzgrp_sequencer #(.IDX_W(W)) i_hzgrp_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .maxvl_i(maxvl),
    .hint_i(hint), .impl_max_i(impl), .unsafe_i(uns), .bat_valid_o(valid),
    .bat_ready_i(ready), .bat_start_o(bstart), .bat_count_o(bcount),
    .bat_indep_o(indep), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int next_mult(input int cur, input int h);
    return ((cur / h) + 1) * h;
  endfunction

  // One full sequence against the bench model; tag names the requirement
  // the configuration targets.
  task automatic run_case(input int v, input int mx, input int hn, input int im,
                          input int un, input int rdy_pct, input bit restart,
                          input string tag);
    int evl, h, isz, sz, cur, guard, e, cnt;
    int p_start, p_cnt;
    bit tried, stalled;
    evl = (v > mx) ? mx : v;
    h = (un != 0) ? 0 : ((hn > mx) ? mx : hn);
    isz = (im == 0) ? 1 : im;
    sz = (h == 0) ? 1 : ((isz < h) ? isz : h);
    cur = 0; guard = 0; tried = 0; stalled = 0; p_start = 0; p_cnt = 0;
    @(negedge clk);
    start = 1'b1; vl = W'(v); maxvl = W'(mx); hint = W'(hn); impl = W'(im);
    uns = 3'(un); ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (evl == 0) begin
      chk(done && !valid, "R10", "done after zero-length start", int'(done), 1);
      @(negedge clk);
      chk(!done && !valid, "R10", "done single cycle", int'(done), 0);
      return;
    end
    while (cur < evl && guard < 2000) begin
      guard++;
      if (!valid) begin
        chk(0, "R2", "batch valid", 0, 1);
        break;
      end
      e = cur + sz;
      if (h != 0 && next_mult(cur, h) < e) e = next_mult(cur, h);
      if (evl < e) e = evl;
      cnt = e - cur;
      if (stalled) begin
        chk(int'(bstart) == p_start && int'(bcount) == p_cnt, "R9",
            "held under back-pressure", int'(bstart), p_start);
      end
      chk(int'(bstart) == cur, "R2", "batch start", int'(bstart), cur);
      chk(int'(bcount) == cnt, tag, "batch count", int'(bcount), cnt);
      chk(int'(bcount) <= sz, "R4", "count within size", int'(bcount), sz);
      chk(indep == (cnt > 1), "R8", "independence flag", int'(indep), int'(cnt > 1));
      if (h != 0 && bcount != 0)
        chk((int'(bstart) / h) == ((int'(bstart) + int'(bcount) - 1) / h), "R3",
            "no group crossing", int'(bcount), cnt);
      if (h == 0)
        chk(bcount == 1 && !indep, "R5", "single element", int'(bcount), 1);
      p_start = int'(bstart); p_cnt = int'(bcount);
      ready = ($urandom_range(99) < rdy_pct);
      if (restart && !tried) begin
        // R11: a start during the run must not disturb the sequence
        start = 1'b1; vl = W'(3); hint = W'(1); uns = 3'b000; tried = 1;
      end
      @(negedge clk);
      start = 1'b0;
      stalled = !ready;
      if (ready) cur = e;
    end
    ready = 1'b0;
    chk(done && !valid, "R10", "done after last batch", int'(done), 1);
    @(negedge clk);
    chk(!done && !valid, restart ? "R11" : "R10", "idle after done", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4092));
    repeat (3) @(negedge clk);
    chk(!valid && !done, "R1", "reset outputs", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !done, "R1", "idle after reset", int'(done), 0);

    run_case(20, 32, 6, 4, 0, 100, 0, "R3");   // non-power-of-two hint, shrunk size
    run_case(17, 32, 5, 8, 0, 60, 0, "R3");
    run_case(9, 32, 0, 8, 0, 100, 0, "R5");
    run_case(8, 32, 8, 8, 3'b001, 100, 0, "R6");
    run_case(8, 32, 8, 8, 3'b010, 70, 0, "R6");
    run_case(8, 32, 8, 8, 3'b100, 100, 0, "R6");
    run_case(10, 12, 100, 16, 0, 100, 0, "R7"); // one batch of 10
    run_case(7, 32, 4, 0, 0, 100, 0, "R4");
    run_case(0, 32, 4, 4, 0, 100, 0, "R10");
    run_case(40, 24, 7, 5, 0, 80, 0, "R12");
    run_case(30, 40, 9, 3, 0, 50, 1, "R11");
    run_case(25, 30, 11, 11, 0, 25, 0, "R9");

    for (int n = 0; n < 40; n++) begin
      int v, mx, hn, im, un;
      mx = $urandom_range(48, 1);
      v = $urandom_range(50, 0);
      hn = $urandom_range(60, 0);
      im = $urandom_range(8, 0);
      un = ($urandom_range(4) == 0) ? (1 << $urandom_range(2)) : 0;
      run_case(v, mx, hn, im, un, $urandom_range(100, 30), n[2], "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule